// File: doc/BRIEF.md
# Interrupt-to-Transfer Request Steering Unit

This block sits between a set of peripheral request flags, a single-channel data transfer engine and a CPU interrupt input. Each source has a transfer-enable bit. When the bit is set, the source's raised flag asks the transfer engine for service. When the bit is clear, the flag becomes a pending CPU interrupt. Software reads and writes the enable bits as one word over a simple register port. Each CPU interrupt line is gated by a per-source mask input.

Only one transfer is outstanding at a time. When several sources want service, a fixed order picks one, and the CPU masks play no part in that choice. The engine reports completion with a done pulse that carries two flags: chain-to-CPU and count-exhausted. If neither is set, the unit strobes the source's clear line and the CPU is never told. If either is set, the unit drops the enable bit and leaves the source flag raised, so the CPU then sees the request as an interrupt. That interrupt is only raised after the done pulse.

Top module: `irq_xfer_steer`

## Requirements
- R1: After a synchronous reset, all enable bits read 0 and irq_out, xfer_req and src_clr are all 0.
- R2: For a source whose enable bit is 0, a raised flag sets irq_out[i] two clock edges after the flag is seen, but only when irq_mask[i] is 1. Such a source never produces xfer_req or src_clr.
- R3: A done with xfer_done_irq=0 and xfer_done_zero=0 gives a src_clr pulse for the granted source in the cycle after done. The enable bit stays 1, and no CPU interrupt is raised.
- R4: A done with xfer_done_irq=1 clears the granted source's enable bit in the cycle after done and issues no src_clr. The source's irq_out then rises one edge after the enable bit reads 0 (mask 1).
- R5: A done with xfer_done_zero=1 behaves as in R4, whatever the value of xfer_done_irq.
- R6: When several enabled sources are raised together, the lowest-numbered one is granted first, whatever the values of irq_mask.
- R7: xfer_req stays high with a stable xfer_src until xfer_ack. No new request appears before the cycle after done. A source whose clear or enable-drop pulse is active is not granted again.
- R8: A source under transfer drives no CPU interrupt before its done has been received.
- R9: A pending CPU interrupt is dropped when the source flag falls. irq_out falls two edges after the flag is seen low.
- R10: A register write that lands in the same cycle as a hardware enable clear loses on that bit. The other bits take the written value.
- R11: reg_rdata always returns the current enable word, with bit i belonging to source i.
- R12: src_clr and the internal enable clear are single-cycle pulses with at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the enable word |
| reg_wdata | input | NUM_SRC | Enable word to write |
| reg_rdata | output | NUM_SRC | Current enable word |
| src_flag | input | NUM_SRC | Peripheral request flags (level) |
| src_clr | output | NUM_SRC | One-cycle clear strobes to the peripherals |
| irq_mask | input | NUM_SRC | Per-source CPU interrupt mask, 1 = pass |
| irq_out | output | NUM_SRC | Masked CPU interrupt lines |
| xfer_req | output | 1 | Transfer request to the engine |
| xfer_src | output | SRC_W | Index of the granted source |
| xfer_ack | input | 1 | Engine accepts the request |
| xfer_done | input | 1 | Engine finished the transfer (one cycle) |
| xfer_done_irq | input | 1 | With done: hand the source on to the CPU |
| xfer_done_zero | input | 1 | With done: transfer count has reached zero |

## Verification
The hardest case to reach is the collision between a software write and the hardware enable clear. The write must land exactly in the cycle after a chained done. The bench gets there by running a full grant, acknowledge and done sequence, then asserting the write on the very next falling edge, and it reads the word back. A second delicate window is the cycle right after done, while the source flag is still high. Here the bench keeps the peripheral model's flag raised until the clear strobe takes effect and checks that the same source is not granted again.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/irq_steer_prio_arb.sv
// Fixed-priority picker: lowest index wins.
module irq_steer_prio_arb #(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [SRC_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = SRC_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_steer_enable_bank.sv
// Per-source transfer-enable bits; hardware clear beats software write.
module irq_steer_enable_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] hw_clr,
  output logic [NUM_SRC-1:0] en
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)            bit_q <= 1'b0;
      else if (hw_clr[i]) bit_q <= 1'b0;
      else if (we)        bit_q <= wdata[i];
    end
    assign en[i] = bit_q;
  end
endmodule

// File: rtl/irq_steer_pend.sv
// CPU-side pending state and registered masked interrupt lines.
module irq_steer_pend #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] flag,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] busy,
  input  logic [NUM_SRC-1:0] chain,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] irq
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic pend_q;
    logic irq_q;
    logic to_cpu;
    assign to_cpu = (!en[i] && !busy[i]) || chain[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        pend_q <= flag[i] && (pend_q || to_cpu);
        irq_q  <= pend_q && mask[i];
      end
    end
    assign irq[i] = irq_q;
  end
endmodule

// File: rtl/irq_xfer_steer.sv
module irq_xfer_steer #(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] src_flag,
  output logic [NUM_SRC-1:0] src_clr,
  input  logic [NUM_SRC-1:0] irq_mask,
  output logic [NUM_SRC-1:0] irq_out,
  output logic               xfer_req,
  output logic [SRC_W-1:0]   xfer_src,
  input  logic               xfer_ack,
  input  logic               xfer_done,
  input  logic               xfer_done_irq,
  input  logic               xfer_done_zero
);
  import irq_steer_pkg::*;

  localparam logic [NUM_SRC-1:0] ONE_HOT_0 = NUM_SRC'(1);

  xfer_state_e        state_q;
  logic [SRC_W-1:0]   gnt_q;
  logic [NUM_SRC-1:0] clr_q;
  logic [NUM_SRC-1:0] en_drop_q;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] busy;
  logic               cand_any;
  logic [SRC_W-1:0]   cand_idx;

  // Sources with a post-done pulse in flight are held out of arbitration.
  assign cand = src_flag & en & ~clr_q & ~en_drop_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_busy
    assign busy[i] = (state_q != ST_IDLE) && (gnt_q == SRC_W'(i));
  end

  irq_steer_prio_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req (cand),
    .any (cand_any),
    .idx (cand_idx)
  );

  irq_steer_enable_bank #(.NUM_SRC(NUM_SRC)) u_en (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .wdata  (reg_wdata),
    .hw_clr (en_drop_q),
    .en     (en)
  );

  irq_steer_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .flag  (src_flag),
    .en    (en),
    .busy  (busy),
    .chain (en_drop_q),
    .mask  (irq_mask),
    .irq   (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      gnt_q     <= '0;
      xfer_req  <= 1'b0;
      clr_q     <= '0;
      en_drop_q <= '0;
    end else begin
      clr_q     <= '0;
      en_drop_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (cand_any) begin
            gnt_q    <= cand_idx;
            xfer_req <= 1'b1;
            state_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (xfer_ack) begin
            xfer_req <= 1'b0;
            state_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (xfer_done) begin
            state_q <= ST_IDLE;
            if (xfer_done_irq || xfer_done_zero)
              en_drop_q <= ONE_HOT_0 << gnt_q;
            else
              clr_q <= ONE_HOT_0 << gnt_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign src_clr   = clr_q;
  assign xfer_src  = gnt_q;
  assign reg_rdata = en;
endmodule

// File: rtl/irq_steer_checker.sv
module irq_steer_checker #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_clr,
  input logic [NUM_SRC-1:0] irq_mask,
  input logic [NUM_SRC-1:0] irq_out,
  input logic               xfer_req,
  input logic [SRC_W-1:0]   xfer_src,
  input logic               xfer_ack,
  input logic               xfer_done
);
  // R12: at most one clear strobe at a time
  a_r12_clr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_clr));

  // R3: a clear strobe follows a done
  a_r3_clr_after_done: assert property (@(posedge clk) disable iff (rst)
    (|src_clr) |-> $past(xfer_done));

  // R7: request held with stable index until acknowledged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_src)));

  // R7: request only drops on an acknowledge
  a_r7_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_req) |-> $past(xfer_ack));

  // R2: an interrupt line is only high if its mask was set
  a_r2_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~$past(irq_mask)) == '0);
endmodule

bind irq_xfer_steer irq_steer_checker #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_clr   (src_clr),
  .irq_mask  (irq_mask),
  .irq_out   (irq_out),
  .xfer_req  (xfer_req),
  .xfer_src  (xfer_src),
  .xfer_ack  (xfer_ack),
  .xfer_done (xfer_done)
);

// File: tb/irq_xfer_steer_bench.sv
module irq_xfer_steer_bench;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] src_flag = '0;
  logic [N-1:0] src_clr;
  logic [N-1:0] irq_mask = '0;
  logic [N-1:0] irq_out;
  logic         xfer_req;
  logic [W-1:0] xfer_src;
  logic         xfer_ack = 1'b0;
  logic         xfer_done = 1'b0;
  logic         xfer_done_irq = 1'b0;
  logic         xfer_done_zero = 1'b0;

  logic [N-1:0] set_v = '0;
  logic [N-1:0] swclr_v = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // peripheral flag model: set by stimulus, cleared by strobe or software
  always @(posedge clk) begin
    if (rst) src_flag <= '0;
    else     src_flag <= (src_flag | set_v) & ~src_clr & ~swclr_v;
  end

  irq_xfer_steer #(.NUM_SRC(N)) u_irq_xfer_steer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_flag(src_flag), .src_clr(src_clr),
    .irq_mask(irq_mask), .irq_out(irq_out), .xfer_req(xfer_req),
    .xfer_src(xfer_src), .xfer_ack(xfer_ack), .xfer_done(xfer_done),
    .xfer_done_irq(xfer_done_irq), .xfer_done_zero(xfer_done_zero)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_en(logic [N-1:0] v);
    reg_we = 1'b1; reg_wdata = v; tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse_set(logic [N-1:0] v);
    set_v = v; tick(); set_v = '0;
  endtask

  task automatic pulse_swclr(logic [N-1:0] v);
    swclr_v = v; tick(); swclr_v = '0;
  endtask

  task automatic wait_req(int exp_src, string tag);
    int n = 0;
    while (!xfer_req && n < 20) begin tick(); n++; end
    chk({tag, " req"}, 32'(xfer_req), 1);
    chk({tag, " src"}, 32'(xfer_src), 32'(exp_src));
  endtask

  // ack, then done with given flags; returns in the cycle after done
  task automatic run_xfer(logic d_irq, logic d_zero);
    xfer_ack = 1'b1; tick(); xfer_ack = 1'b0;
    tick();
    xfer_done = 1'b1; xfer_done_irq = d_irq; xfer_done_zero = d_zero;
    tick();
    xfer_done = 1'b0; xfer_done_irq = 1'b0; xfer_done_zero = 1'b0;
  endtask

  task automatic cleanup();
    pulse_swclr('1);
    write_en('0);
    repeat (3) tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) tick(); rst = 1'b0; tick();
    chk("R1 en", 32'(reg_rdata), 0);
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 req", 32'(xfer_req), 0);
    chk("R1 clr", 32'(src_clr), 0);
  endtask

  task automatic t_cpu_path();
    irq_mask = 8'h08;
    pulse_set(8'h18);
    tick();
    chk("R2 irq early", 32'(irq_out), 0);
    tick();
    chk("R2 irq masked", 32'(irq_out), 32'h08);
    chk("R2 no req", 32'(xfer_req), 0);
    chk("R2 no clr", 32'(src_clr), 0);
    pulse_swclr(8'h18);
    tick();
    chk("R9 irq held", 32'(irq_out), 32'h08);
    tick();
    chk("R9 irq dropped", 32'(irq_out), 0);
    cleanup();
  endtask

  task automatic t_plain();
    irq_mask = '1;
    write_en(8'h02);
    chk("R11 readback", 32'(reg_rdata), 32'h02);
    pulse_set(8'h02);
    wait_req(1, "R3");
    run_xfer(1'b0, 1'b0);
    chk("R3 clr pulse", 32'(src_clr), 32'h02);
    tick();
    chk("R12 clr single", 32'(src_clr), 0);
    chk("R3 flag cleared", 32'(src_flag), 0);
    chk("R3 en kept", 32'(reg_rdata), 32'h02);
    chk("R7 no regrant", 32'(xfer_req), 0);
    repeat (3) tick();
    chk("R3 no irq", 32'(irq_out), 0);
    cleanup();
  endtask

  task automatic t_chain(logic d_irq, logic d_zero, int src, string tag);
    logic [N-1:0] b = N'(1) << src;
    irq_mask = '1;
    write_en(b);
    pulse_set(b);
    wait_req(src, tag);
    repeat (3) tick();
    chk("R8 no irq in transfer", 32'(irq_out), 0);
    run_xfer(d_irq, d_zero);
    chk({tag, " no clr"}, 32'(src_clr), 0);
    chk("R8 no irq at done", 32'(irq_out), 0);
    tick();
    chk({tag, " en dropped"}, 32'(reg_rdata), 0);
    tick();
    chk({tag, " irq raised"}, 32'(irq_out), 32'(b));
    chk({tag, " flag kept"}, 32'(src_flag), 32'(b));
    chk("R7 no regrant", 32'(xfer_req), 0);
    cleanup();
  endtask

  task automatic t_prio();
    irq_mask = '0;
    write_en(8'h24);
    pulse_set(8'h24);
    wait_req(2, "R6");
    run_xfer(1'b0, 1'b0);
    chk("R7 idle after done", 32'(xfer_req), 0);
    tick();
    wait_req(5, "R6 second");
    repeat (4) tick();
    chk("R7 held", 32'(xfer_req), 1);
    chk("R7 src stable", 32'(xfer_src), 5);
    run_xfer(1'b0, 1'b0);
    chk("R6 clr second", 32'(src_clr), 32'h20);
    repeat (3) tick();
    chk("R6 no irq", 32'(irq_out), 0);
    cleanup();
  endtask

  task automatic t_collide();
    irq_mask = '1;
    write_en(8'h08);
    pulse_set(8'h08);
    wait_req(3, "R10");
    xfer_ack = 1'b1; tick(); xfer_ack = 1'b0;
    tick();
    xfer_done = 1'b1; xfer_done_irq = 1'b1; tick();
    xfer_done = 1'b0; xfer_done_irq = 1'b0;
    reg_we = 1'b1; reg_wdata = 8'hFF; tick();
    reg_we = 1'b0;
    chk("R10 hw clear wins", 32'(reg_rdata), 32'hF7);
    write_en('0);
    cleanup();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cpu_path();
    t_plain();
    t_chain(1'b1, 1'b0, 6, "R4");
    t_chain(1'b0, 1'b1, 0, "R5");
    t_chain(1'b1, 1'b1, 7, "R5 both");
    t_prio();
    t_collide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule